// File: doc/BRIEF.md
# Serial Port FIFO Interrupt Generator

This block holds the receive and transmit queues of a synchronous serial port and turns their fill levels into two interrupt requests. Both queues are 16 words of 16 bits by default, each with its own push and pop port, so occupancy is tracked inside the block. The serial shifter (not part of this block) pushes received words and pops words to send. Software reads and refills the queues through the other side of each port.

The receive request works with hysteresis. It is raised once the receive queue reaches half its depth. After that it stays raised while any word remains, and drops only when the queue is drained. The transmit request follows a low-water mark: it is high while the transmit queue holds fewer than half its depth and low otherwise. Each direction has an enable. Turning an enable on takes effect at the next clock edge. Turning it off is held off until a serial-clock tick arrives. The tick is a one-cycle strobe in the system clock domain. While a direction is effectively off, its request stays low.

Top module: `ssi_irq_ctrl`

## Requirements
- R1: Each queue returns words in the order they were accepted. The level output counts the stored words and changes by at most one per cycle. A push and a pop in the same cycle on a queue that is neither empty nor full leave the level unchanged.
- R2: A push into a full queue (level = DEPTH) is dropped. A pop from an empty queue is dropped, and the level stays 0. With both push and pop on a full queue, only the pop is accepted.
- R3: While receive is effectively enabled, rx_irq goes high in the same cycle that rx_level first shows DEPTH/2 (8) or more. Below that level, if the request was not already raised, it stays low.
- R4: Once raised, rx_irq stays high while rx_level drops below DEPTH/2, down to 1. It goes low in the cycle rx_level shows 0.
- R5: After rx_enable goes low, a raised rx_irq stays high through every clock edge that has no tick. It goes low after the first clock edge at which sclk_tick is high and rx_enable is low.
- R6: While transmit is effectively enabled, tx_irq is high exactly when tx_level is below DEPTH/2 (8).
- R7: After tx_enable goes low, tx_irq keeps following R6 until the first clock edge at which sclk_tick is high and tx_enable is low. After that edge, tx_irq is low.
- R8: A direction becomes effectively enabled one clock edge after its enable is seen high. Until then, and whenever it is effectively off, its request is low whatever the level. Re-enabling does not bring back an earlier raised receive request: a receive level between 1 and 7 gives rx_irq = 0.
- R9: While reset is high, and in the first cycle after it, both levels read 0, both requests are low and both directions are effectively disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_enable | input | 1 | Receive direction enable |
| tx_enable | input | 1 | Transmit direction enable |
| sclk_tick | input | 1 | One-cycle serial-clock strobe used to apply disables |
| rx_push | input | 1 | Write strobe into the receive queue |
| rx_push_data | input | WIDTH | Word written into the receive queue |
| rx_pop | input | 1 | Read strobe from the receive queue |
| rx_pop_data | output | WIDTH | Oldest word in the receive queue (valid when not empty) |
| rx_level | output | $clog2(DEPTH+1) | Receive queue occupancy |
| tx_push | input | 1 | Write strobe into the transmit queue |
| tx_push_data | input | WIDTH | Word written into the transmit queue |
| tx_pop | input | 1 | Read strobe from the transmit queue |
| tx_pop_data | output | WIDTH | Oldest word in the transmit queue (valid when not empty) |
| tx_level | output | $clog2(DEPTH+1) | Transmit queue occupancy |
| rx_irq | output | 1 | Receive request with hysteresis |
| tx_irq | output | 1 | Transmit low-water request |

## Verification
The bench builds the block with its default values, WIDTH = 16 and DEPTH = 16. With these values both the half-depth mark at 8 and the full mark at 16 can be reached in a few dozen pushes. The bench walks each queue from empty through the mark to full and back. This covers the overflow and underflow drops, the hysteresis band from 7 down to 1, and the cycles in which a disable is pending while no tick has yet arrived.

// File: rtl/ssi_irq_pkg.sv
package ssi_irq_pkg;

    localparam int DEF_WIDTH = 16;
    localparam int DEF_DEPTH = 16;

    localparam int DIR_RX  = 0;
    localparam int DIR_TX  = 1;
    localparam int NUM_DIR = 2;

    // One cycle's request to a queue
    typedef struct packed {
        logic push;
        logic pop;
    } fifo_req_t;

    // Receive request hysteresis state
    typedef enum logic {
        RXI_QUIET = 1'b0,
        RXI_ARMED = 1'b1
    } rxi_state_e;

    // Level at which the receive request rises and below which transmit requests
    function automatic int mark_of(input int depth);
        return depth / 2;
    endfunction

endpackage

// File: rtl/ssi_fifo.sv
module ssi_fifo
    import ssi_irq_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH,
    parameter int DEPTH = DEF_DEPTH,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  fifo_req_t        req,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_data,
    output logic [LVL_W-1:0] level
);

    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             wr_ok, rd_ok;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    assign wr_ok   = req.push && (level != FULL_LVL);
    assign rd_ok   = req.pop  && (level != '0);
    assign rd_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (wr_ok) wr_ptr <= bump(wr_ptr);
            if (rd_ok) rd_ptr <= bump(rd_ptr);
            case ({wr_ok, rd_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/ssi_dis_sync.sv
module ssi_dis_sync (
    input  logic clk,
    input  logic rst,
    input  logic en_req,
    input  logic tick,
    output logic en_eff
);

    // Enabling lands on the next edge; disabling waits for a serial tick.
    always_ff @(posedge clk) begin
        if (rst) begin
            en_eff <= 1'b0;
        end else if (en_req) begin
            en_eff <= 1'b1;
        end else if (tick) begin
            en_eff <= 1'b0;
        end
    end

endmodule

// File: rtl/ssi_irq_gen.sv
module ssi_irq_gen
    import ssi_irq_pkg::*;
#(
    parameter int DEPTH = DEF_DEPTH,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_on,
    input  logic             tx_on,
    input  logic [LVL_W-1:0] rx_lvl,
    input  logic [LVL_W-1:0] tx_lvl,
    output logic             rx_irq,
    output logic             tx_irq
);

    localparam logic [LVL_W-1:0] MARK = LVL_W'(mark_of(DEPTH));

    rxi_state_e rx_state;
    logic       rx_hit, rx_keep;

    assign rx_hit  = (rx_lvl >= MARK);
    assign rx_keep = (rx_state == RXI_ARMED) && (rx_lvl != '0);
    assign rx_irq  = rx_on && (rx_hit || rx_keep);
    assign tx_irq  = tx_on && (tx_lvl < MARK);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_state <= RXI_QUIET;
        end else begin
            rx_state <= rx_irq ? RXI_ARMED : RXI_QUIET;
        end
    end

endmodule

// File: rtl/ssi_irq_ctrl.sv
module ssi_irq_ctrl
    import ssi_irq_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH,
    parameter int DEPTH = DEF_DEPTH,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_enable,
    input  logic             tx_enable,
    input  logic             sclk_tick,
    input  logic             rx_push,
    input  logic [WIDTH-1:0] rx_push_data,
    input  logic             rx_pop,
    output logic [WIDTH-1:0] rx_pop_data,
    output logic [LVL_W-1:0] rx_level,
    input  logic             tx_push,
    input  logic [WIDTH-1:0] tx_push_data,
    input  logic             tx_pop,
    output logic [WIDTH-1:0] tx_pop_data,
    output logic [LVL_W-1:0] tx_level,
    output logic             rx_irq,
    output logic             tx_irq
);

    fifo_req_t        dir_req   [NUM_DIR];
    logic [WIDTH-1:0] dir_wdata [NUM_DIR];
    logic [WIDTH-1:0] dir_rdata [NUM_DIR];
    logic [LVL_W-1:0] dir_lvl   [NUM_DIR];
    logic             dir_en    [NUM_DIR];
    logic             dir_on    [NUM_DIR];

    always_comb begin
        dir_req[DIR_RX]   = '{push: rx_push, pop: rx_pop};
        dir_req[DIR_TX]   = '{push: tx_push, pop: tx_pop};
        dir_wdata[DIR_RX] = rx_push_data;
        dir_wdata[DIR_TX] = tx_push_data;
        dir_en[DIR_RX]    = rx_enable;
        dir_en[DIR_TX]    = tx_enable;
    end

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        ssi_fifo #(
            .WIDTH (WIDTH),
            .DEPTH (DEPTH)
        ) u_fifo (
            .clk     (clk),
            .rst     (rst),
            .req     (dir_req[d]),
            .wr_data (dir_wdata[d]),
            .rd_data (dir_rdata[d]),
            .level   (dir_lvl[d])
        );

        ssi_dis_sync u_sync (
            .clk    (clk),
            .rst    (rst),
            .en_req (dir_en[d]),
            .tick   (sclk_tick),
            .en_eff (dir_on[d])
        );
    end

    ssi_irq_gen #(
        .DEPTH (DEPTH)
    ) u_irq (
        .clk    (clk),
        .rst    (rst),
        .rx_on  (dir_on[DIR_RX]),
        .tx_on  (dir_on[DIR_TX]),
        .rx_lvl (dir_lvl[DIR_RX]),
        .tx_lvl (dir_lvl[DIR_TX]),
        .rx_irq (rx_irq),
        .tx_irq (tx_irq)
    );

    assign rx_pop_data = dir_rdata[DIR_RX];
    assign tx_pop_data = dir_rdata[DIR_TX];
    assign rx_level    = dir_lvl[DIR_RX];
    assign tx_level    = dir_lvl[DIR_TX];

endmodule

// File: rtl/ssi_irq_ctrl_chk.sv
module ssi_irq_ctrl_chk #(
    parameter int DEPTH = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_enable,
    input logic             tx_enable,
    input logic             sclk_tick,
    input logic             rx_push,
    input logic             rx_pop,
    input logic [LVL_W-1:0] rx_level,
    input logic [LVL_W-1:0] tx_level,
    input logic             rx_irq,
    input logic             tx_irq
);

    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
    localparam logic [LVL_W-1:0] MARK     = LVL_W'(DEPTH / 2);

    // R2: levels never pass the depth
    p_level_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (rx_level <= FULL_LVL) && (tx_level <= FULL_LVL));

    // R2: push alone into a full receive queue is dropped
    p_full_push_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(rx_level) == FULL_LVL && $past(rx_push) && !$past(rx_pop)
        |-> rx_level == FULL_LVL);

    // R1: level moves by at most one per cycle
    p_level_step_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |->
        (int'(rx_level) <= int'($past(rx_level)) + 1) &&
        (int'(rx_level) + 1 >= int'($past(rx_level))));

    // R3: steady enable and level at the mark means a raised request
    p_rx_set_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(rx_enable) && rx_enable && rx_level >= MARK |-> rx_irq);

    // R4: an empty receive queue never requests
    p_rx_empty_r4: assert property (@(posedge clk) disable iff (rst)
        rx_level == '0 |-> !rx_irq);

    // R5: without a tick a raised request survives while words remain
    p_rx_pending_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(rx_irq) && !$past(sclk_tick) && rx_level != '0 |-> rx_irq);

    // R5: tick while disabled drops the receive request
    p_rx_off_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(!rx_enable && sclk_tick) && !rx_enable |-> !rx_irq);

    // R6: steady transmit enable makes the request follow the low-water mark
    p_tx_track_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(tx_enable) && tx_enable |-> tx_irq == (tx_level < MARK));

    // R7: tick while disabled drops the transmit request
    p_tx_off_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(!tx_enable && sclk_tick) && !tx_enable |-> !tx_irq);

    // R9: first cycle after reset is quiet
    p_reset_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rx_irq && !tx_irq && rx_level == '0 && tx_level == '0);

endmodule

bind ssi_irq_ctrl ssi_irq_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_enable (rx_enable),
    .tx_enable (tx_enable),
    .sclk_tick (sclk_tick),
    .rx_push   (rx_push),
    .rx_pop    (rx_pop),
    .rx_level  (rx_level),
    .tx_level  (tx_level),
    .rx_irq    (rx_irq),
    .tx_irq    (tx_irq)
);

// File: tb/ssi_irq_ctrl_test.sv
`timescale 1ns/1ps
module ssi_irq_ctrl_test;

    localparam int WIDTH = 16;
    localparam int DEPTH = 16;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rx_enable = 1'b0, tx_enable = 1'b0, sclk_tick = 1'b0;
    logic             rx_push = 1'b0, rx_pop = 1'b0, tx_push = 1'b0, tx_pop = 1'b0;
    logic [WIDTH-1:0] rx_push_data = '0, tx_push_data = '0;
    logic [WIDTH-1:0] rx_pop_data, tx_pop_data;
    logic [LVL_W-1:0] rx_level, tx_level;
    logic             rx_irq, tx_irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [WIDTH-1:0] rxq[$];
    logic [WIDTH-1:0] txq[$];

    always #4 clk = ~clk;

    ssi_irq_ctrl #(.WIDTH(WIDTH), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst),
        .rx_enable(rx_enable), .tx_enable(tx_enable), .sclk_tick(sclk_tick),
        .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_pop(rx_pop),
        .rx_pop_data(rx_pop_data), .rx_level(rx_level),
        .tx_push(tx_push), .tx_push_data(tx_push_data), .tx_pop(tx_pop),
        .tx_pop_data(tx_pop_data), .tx_level(tx_level),
        .rx_irq(rx_irq), .tx_irq(tx_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Scoreboard monitor: mid-cycle, compare levels and popped words with the queues
    always @(negedge clk) begin
        #2;
        if (!rst && !done) begin
            int rs, ts;
            rs = rxq.size();
            ts = txq.size();
            chk(int'(rx_level) == rs, "R1 rx level", int'(rx_level), rs);
            chk(int'(tx_level) == ts, "R1 tx level", int'(tx_level), ts);
            if (rx_pop && rs > 0) begin
                logic [WIDTH-1:0] e;
                e = rxq.pop_front();
                chk(rx_pop_data == e, "R1 rx order", int'(rx_pop_data), int'(e));
            end
            if (rx_push && rs < DEPTH) rxq.push_back(rx_push_data);
            if (tx_pop && ts > 0) begin
                logic [WIDTH-1:0] e;
                e = txq.pop_front();
                chk(tx_pop_data == e, "R1 tx order", int'(tx_pop_data), int'(e));
            end
            if (tx_push && ts < DEPTH) txq.push_back(tx_push_data);
        end
    end

    task automatic next();
        @(negedge clk);
        rx_push = 1'b0; rx_pop = 1'b0; tx_push = 1'b0; tx_pop = 1'b0; sclk_tick = 1'b0;
    endtask

    task automatic push_rx(input logic [WIDTH-1:0] d);
        rx_push = 1'b1; rx_push_data = d; next();
    endtask
    task automatic pop_rx();
        rx_pop = 1'b1; next();
    endtask
    task automatic push_tx(input logic [WIDTH-1:0] d);
        tx_push = 1'b1; tx_push_data = d; next();
    endtask
    task automatic pop_tx();
        tx_pop = 1'b1; next();
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        done = 1'b1;
        failures++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(rx_level == 0 && tx_level == 0, "R9 levels in reset", int'(rx_level), 0);
        chk(!rx_irq && !tx_irq, "R9 irqs in reset", int'({rx_irq, tx_irq}), 0);
        rst = 1'b0;
        next();
        chk(!rx_irq && !tx_irq, "R9 irqs after reset", int'({rx_irq, tx_irq}), 0);

        // R8: enable lands one edge later
        rx_enable = 1'b1; tx_enable = 1'b1;
        chk(!tx_irq, "R8 before enable edge", int'(tx_irq), 0);
        next();
        chk(tx_irq, "R6 empty tx requests", int'(tx_irq), 1);
        chk(!rx_irq, "R3 empty rx quiet", int'(rx_irq), 0);

        // R3: rise exactly at 8
        for (int i = 1; i <= 7; i++) begin
            push_rx(16'h1000 + 16'(i));
            chk(!rx_irq, "R3 below mark", int'(rx_irq), 0);
        end
        push_rx(16'h1008);
        chk(rx_irq, "R3 at mark", int'(rx_irq), 1);
        for (int i = 9; i <= 16; i++) push_rx(16'h1000 + 16'(i));
        chk(rx_level == 16, "R2 rx full", int'(rx_level), 16);
        push_rx(16'hDEAD);
        chk(rx_level == 16, "R2 push to full dropped", int'(rx_level), 16);

        // R4: hysteresis down to 1
        for (int i = 15; i >= 1; i--) begin
            pop_rx();
            chk(rx_irq, "R4 held while draining", int'(rx_irq), 1);
        end
        pop_rx();
        chk(!rx_irq, "R4 clear on empty", int'(rx_irq), 0);
        pop_rx();
        chk(rx_level == 0, "R2 pop empty dropped", int'(rx_level), 0);
        chk(!rx_irq, "R4 empty stays quiet", int'(rx_irq), 0);

        // R1: simultaneous push and pop
        for (int i = 0; i < 3; i++) push_rx(16'h2000 + 16'(i));
        rx_push = 1'b1; rx_push_data = 16'h2003; rx_pop = 1'b1; next();
        chk(rx_level == 3, "R1 push+pop keeps level", int'(rx_level), 3);
        for (int i = 0; i < 3; i++) pop_rx();

        // R2: push+pop on full accepts only the pop
        for (int i = 0; i < 16; i++) push_rx(16'h3000 + 16'(i));
        rx_push = 1'b1; rx_push_data = 16'hBEEF; rx_pop = 1'b1; next();
        chk(rx_level == 15, "R2 full push+pop", int'(rx_level), 15);
        for (int i = 0; i < 15; i++) pop_rx();

        // R5: pending disable
        for (int i = 0; i < 9; i++) push_rx(16'h4000 + 16'(i));
        chk(rx_irq, "R3 raised at 9", int'(rx_irq), 1);
        rx_enable = 1'b0;
        for (int i = 0; i < 3; i++) begin
            next();
            chk(rx_irq, "R5 held until tick", int'(rx_irq), 1);
        end
        sclk_tick = 1'b1; next();
        chk(!rx_irq, "R5 cleared after tick", int'(rx_irq), 0);
        push_rx(16'h4009);
        chk(!rx_irq, "R8 off ignores level", int'(rx_irq), 0);
        rx_enable = 1'b1;
        chk(!rx_irq, "R8 not yet on", int'(rx_irq), 0);
        next();
        chk(rx_irq, "R8 on after one edge", int'(rx_irq), 1);
        for (int i = 0; i < 5; i++) pop_rx();
        chk(rx_level == 5 && rx_irq, "R4 held at 5", int'(rx_irq), 1);
        rx_enable = 1'b0; sclk_tick = 1'b1; next();
        chk(!rx_irq, "R5 tick clears", int'(rx_irq), 0);
        rx_enable = 1'b1; next();
        chk(!rx_irq, "R8 rearm not restored", int'(rx_irq), 0);
        sclk_tick = 1'b1; next();
        chk(!rx_irq, "R8 tick while on no effect", int'(rx_irq), 0);
        for (int i = 0; i < 3; i++) push_rx(16'h5000 + 16'(i));
        chk(rx_irq, "R3 reach 8 again", int'(rx_irq), 1);
        for (int i = 0; i < 8; i++) pop_rx();
        chk(!rx_irq && rx_level == 0, "R4 drained", int'(rx_irq), 0);

        // R6: transmit low-water
        for (int i = 1; i <= 7; i++) begin
            push_tx(16'h6000 + 16'(i));
            chk(tx_irq, "R6 below mark", int'(tx_irq), 1);
        end
        push_tx(16'h6008);
        chk(!tx_irq, "R6 at mark", int'(tx_irq), 0);
        for (int i = 9; i <= 16; i++) push_tx(16'h6000 + 16'(i));
        push_tx(16'hDEAD);
        chk(tx_level == 16, "R2 tx push to full dropped", int'(tx_level), 16);
        for (int i = 0; i < 8; i++) pop_tx();
        chk(!tx_irq, "R6 at 8 quiet", int'(tx_irq), 0);
        pop_tx();
        chk(tx_irq, "R6 at 7 requests", int'(tx_irq), 1);
        push_tx(16'h6100);
        chk(!tx_irq, "R6 refilled clears", int'(tx_irq), 0);
        for (int i = 0; i < 3; i++) pop_tx();
        chk(tx_irq && tx_level == 5, "R6 at 5", int'(tx_irq), 1);

        // R7: pending transmit disable
        tx_enable = 1'b0;
        for (int i = 0; i < 2; i++) begin
            next();
            chk(tx_irq, "R7 held until tick", int'(tx_irq), 1);
        end
        sclk_tick = 1'b1; next();
        chk(!tx_irq, "R7 cleared after tick", int'(tx_irq), 0);
        tx_enable = 1'b1; next();
        chk(tx_irq, "R8 tx back on", int'(tx_irq), 1);
        for (int i = 0; i < 5; i++) pop_tx();
        pop_tx();
        chk(tx_level == 0, "R2 tx pop empty dropped", int'(tx_level), 0);

        next();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule